// File: doc/BRIEF.md
# Asynchronous Parallel-Bus Peripheral Register Slave

This block is the peripheral-side end of an 8-bit parallel bus. The bus is driven by a microprocessor whose timing has no relation to the peripheral clock. The processor drives an address bus and a bidirectional data bus. It also drives five control lines: one active-high bus reset, active-low read and write strobes, and two active-low select lines. The slave turns these into writes to a small register bank in its own clock domain, and it returns register contents onto the shared data bus.

The write, read and select lines pass through synchronizer chains. A write takes effect once, on the synchronized falling edge of the write strobe. The data bus is driven only while a selected read is in progress. The drive is released in the same instant that read or select goes inactive, so the slave never fights the processor for the bus. A parameter chooses which of the two select lines this instance answers to. The register contents and a one-cycle write pulse with its index are brought out to the peripheral logic behind the slave.

Top module: `pbus_slave`

## Requirements
- R1: While `bus_rst` is high, every register in `reg_bank` reads 0, `bus_drive` is 0 and `wr_pulse` is 0, with no clock edge needed.
- R2: A write takes effect when this instance's select line is low and `wr_n` falls with `rd_n` high. It stores the value on `data_io` into register `addr_in` (register k is `reg_bank[8k+7:8k]`). The new value is visible no later than four clock cycles after the strobe falls.
- R3: Each low period of `wr_n` produces exactly one `wr_pulse` of one clock cycle, however long the strobe stays low.
- R4: With the default select choice (`sel_n[0]`), the slave writes nothing and drives nothing when only `sel_n[1]` is low.
- R5: When the slave is selected with `rd_n` low and `wr_n` high, it drives the addressed register onto `data_io` no later than three clock cycles after the strobe falls.
- R6: `bus_drive` is high only while `rd_n` is low, `wr_n` is high and the chosen select line is low. It falls in the same time step that any of these stops holding.
- R7: If read and write are both low at the same time, nothing is written and the bus is not driven.
- R8: An address at or above the register count reads as 0 and does not change any register or raise `wr_pulse`.
- R9: While read and write are both high, registers stay unchanged and the bus stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| bus_rst | input | 1 | Bus-wide reset, active high, asynchronous |
| addr_in | input | 8 | Register address from the processor |
| data_io | inout | 8 | Shared data bus |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| sel_n | input | 2 | The two module-select lines, active low |
| bus_drive | output | 1 | High while the slave drives `data_io` |
| wr_pulse | output | 1 | One-cycle pulse for each committed write |
| wr_idx | output | 8 | Register index of the committed write |
| reg_bank | output | 32 | All registers, register k at bits 8k+7:8k |

## Verification
Some properties are checked on every cycle. The drive enable never rises without a live, selected, read-only strobe. A write pulse never lasts two cycles and never names an unimplemented register. The register bank changes only after a pulse, and reset leaves the bank clear. Other behaviour can only be shown by the bench's scenarios: the value actually stored or returned, the count of one pulse per strobe, the other select line being ignored, and an out-of-range read returning zero.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   // active-high view of the asynchronous control lines
   typedef struct packed {
      logic wr;
      logic rd;
      logic sel;
   } strobe_t;

   localparam int STROBE_W = $bits(strobe_t);

   function automatic logic addr_hit(input logic [31:0] a, input int unsigned n);
      return a < n;
   endfunction
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or posedge rst)
               if (rst) chain[s] <= '0;
               else     chain[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or posedge rst)
               if (rst) chain[s] <= '0;
               else     chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pbus_front.sv
module pbus_front
   import pbus_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst,
   input  strobe_t raw,
   output logic    commit,
   output logic    rd_live
);
   strobe_t synced;
   logic    wr_prev;

   pbus_sync #(.STAGES(SYNC_STAGES), .W(STROBE_W)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (synced)
   );

   always_ff @(posedge clk or posedge rst)
      if (rst) wr_prev <= 1'b0;
      else     wr_prev <= synced.wr;

   // strobe start seen once; a read held at the same time voids the cycle
   assign commit  = synced.wr & ~wr_prev & synced.sel & ~synced.rd;
   assign rd_live = synced.rd & synced.sel & ~synced.wr;
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [ADDR_W-1:0]          raddr,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] bank
);
   logic [DATA_W-1:0] cells [NUM_REGS];

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
         always_ff @(posedge clk or posedge rst)
            if (rst)                                 cells[k] <= '0;
            else if (we && waddr == ADDR_W'(k))      cells[k] <= wdata;
         assign bank[k*DATA_W +: DATA_W] = cells[k];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (raddr == ADDR_W'(k)) rdata = cells[k];
   end
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
   import pbus_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 4,
   parameter int SEL_INDEX   = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       bus_rst,
   input  logic [ADDR_W-1:0]          addr_in,
   inout  wire  [DATA_W-1:0]          data_io,
   input  logic                       wr_n,
   input  logic                       rd_n,
   input  logic [1:0]                 sel_n,
   output logic                       bus_drive,
   output logic                       wr_pulse,
   output logic [ADDR_W-1:0]          wr_idx,
   output logic [NUM_REGS*DATA_W-1:0] reg_bank
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NUM_REGS < 1 || NUM_REGS > ADDR_SPAN) begin : g_bad_regs
      $error("NUM_REGS must fit the address space");
   end
   if (SEL_INDEX < 0 || SEL_INDEX > 1) begin : g_bad_sel
      $error("SEL_INDEX must be 0 or 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              sel_act;
   strobe_t           raw;
   logic              commit, rd_live, in_range;
   logic [DATA_W-1:0] rdata;

   generate
      if (SEL_INDEX == 0) begin : g_sel0
         assign sel_act = ~sel_n[0];
      end else begin : g_sel1
         assign sel_act = ~sel_n[1];
      end
   endgenerate

   assign raw.wr  = ~wr_n;
   assign raw.rd  = ~rd_n;
   assign raw.sel = sel_act;

   pbus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk     (clk),
      .rst     (bus_rst),
      .raw     (raw),
      .commit  (commit),
      .rd_live (rd_live)
   );

   assign in_range = addr_hit(32'(addr_in), NUM_REGS);
   assign wr_pulse = commit & in_range;
   assign wr_idx   = addr_in;

   pbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk   (clk),
      .rst   (bus_rst),
      .we    (wr_pulse),
      .waddr (addr_in),
      .wdata (data_io),
      .raddr (addr_in),
      .rdata (rdata),
      .bank  (reg_bank)
   );

   // synchronized qualifier turns on; raw pins turn off without delay
   assign bus_drive = rd_live & ~rd_n & wr_n & sel_act & ~bus_rst;
   assign data_io   = bus_drive ? rdata : 'z;
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_REGS  = 4,
   parameter int SEL_INDEX = 0
) (
   input logic                       clk,
   input logic                       bus_rst,
   input logic [ADDR_W-1:0]          addr_in,
   input logic                       wr_n,
   input logic                       rd_n,
   input logic [1:0]                 sel_n,
   input logic                       bus_drive,
   input logic                       wr_pulse,
   input logic [ADDR_W-1:0]          wr_idx,
   input logic [NUM_REGS*DATA_W-1:0] reg_bank
);
   always @(posedge clk)
      if (bus_rst) begin
         p_reset_clears_r1: assert (reg_bank == '0 && !bus_drive && !wr_pulse);
      end

   p_drive_needs_read_r6: assert property (@(posedge clk) disable iff (bus_rst)
      bus_drive |-> (!rd_n && wr_n && !sel_n[SEL_INDEX]));

   p_no_drive_on_clash_r7: assert property (@(posedge clk) disable iff (bus_rst)
      (!rd_n && !wr_n) |-> !bus_drive);

   p_single_pulse_r3: assert property (@(posedge clk) disable iff (bus_rst)
      wr_pulse |=> !wr_pulse);

   p_pulse_in_range_r8: assert property (@(posedge clk) disable iff (bus_rst)
      wr_pulse |-> (32'(wr_idx) < NUM_REGS));

   p_bank_moves_on_pulse_r2: assert property (@(posedge clk) disable iff (bus_rst)
      !wr_pulse |=> $stable(reg_bank));
endmodule

bind pbus_slave pbus_slave_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_INDEX(SEL_INDEX)
) u_chk (
   .clk(clk), .bus_rst(bus_rst), .addr_in(addr_in), .wr_n(wr_n), .rd_n(rd_n),
   .sel_n(sel_n), .bus_drive(bus_drive), .wr_pulse(wr_pulse), .wr_idx(wr_idx),
   .reg_bank(reg_bank)
);

// File: tb/tb_pbus_slave.sv
module tb_pbus_slave;
   logic       clk = 1'b0;
   logic       bus_rst = 1'b1;
   logic [7:0] addr_in = '0;
   logic       wr_n = 1'b1, rd_n = 1'b1;
   logic [1:0] sel_n = 2'b11;
   logic [7:0] host_d = '0;
   logic       host_en = 1'b0;
   wire  [7:0] dbus;
   logic       bus_drive, wr_pulse;
   logic [7:0] wr_idx;
   logic [31:0] reg_bank;

   int checks = 0, errors = 0, pulses = 0;

   assign dbus = host_en ? host_d : 8'hzz;

   always #2 clk = ~clk;   // 250 MHz

   pbus_slave dut (
      .clk(clk), .bus_rst(bus_rst), .addr_in(addr_in), .data_io(dbus),
      .wr_n(wr_n), .rd_n(rd_n), .sel_n(sel_n), .bus_drive(bus_drive),
      .wr_pulse(wr_pulse), .wr_idx(wr_idx), .reg_bank(reg_bank)
   );

   always @(posedge clk) if (wr_pulse) pulses <= pulses + 1;

   // {is_read, addr, data/expected}
   localparam int NV = 11;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 8'd0, 8'hA5}, {1'b0, 8'd1, 8'h3C}, {1'b0, 8'd2, 8'hFF},
      {1'b0, 8'd3, 8'h81}, {1'b1, 8'd0, 8'hA5}, {1'b1, 8'd1, 8'h3C},
      {1'b1, 8'd2, 8'hFF}, {1'b1, 8'd3, 8'h81}, {1'b0, 8'd1, 8'h5A},
      {1'b1, 8'd1, 8'h5A}, {1'b1, 8'd0, 8'hA5}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] sel, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); addr_in = a; host_d = d; host_en = 1'b1; sel_n = sel;
      @(negedge clk); wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk); sel_n = 2'b11; host_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // returns {drive, data} sampled while the strobe is held, plus drive after release
   task automatic bus_read(input logic [1:0] sel, input logic [7:0] a,
                           output logic [7:0] d, output logic drv, output logic drv_after);
      @(negedge clk); addr_in = a; sel_n = sel;
      @(negedge clk); rd_n = 1'b0;
      repeat (3) @(negedge clk);
      d = dbus; drv = bus_drive;
      rd_n = 1'b1;
      #0.5 drv_after = bus_drive;
      @(negedge clk); sel_n = 2'b11;
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [7:0] reg_of(input int k);
      return reg_bank[k*8 +: 8];
   endfunction

   initial begin
      logic [7:0] rd; logic drv, drv_after;
      logic [31:0] snap; int p0;
      // R1: reset state
      #1;
      check("R1 bank in reset", reg_bank, 32'h0);
      check("R1 drive in reset", {31'b0, bus_drive}, 32'h0);
      repeat (3) @(negedge clk);
      bus_rst = 1'b0;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][16]) begin
            bus_read(2'b10, VEC[i][15:8], rd, drv, drv_after);
            check("R5 read data", {24'b0, rd}, {24'b0, VEC[i][7:0]});
            check("R5 drive on read", {31'b0, drv}, 32'h1);
            check("R6 release at once", {31'b0, drv_after}, 32'h0);
         end else begin
            bus_write(2'b10, VEC[i][15:8], VEC[i][7:0]);
            check("R2 stored value", {24'b0, reg_of(int'(VEC[i][15:8]))}, {24'b0, VEC[i][7:0]});
         end
      end
      check("R3 one pulse per strobe", pulses, 32'd5);

      // R4: only the other select line low
      p0 = pulses; snap = reg_bank;
      bus_write(2'b01, 8'd0, 8'h11);
      check("R4 unselected write ignored", reg_bank, snap);
      check("R4 no pulse when unselected", pulses, p0);
      bus_read(2'b01, 8'd0, rd, drv, drv_after);
      check("R4 no drive when unselected", {31'b0, drv}, 32'h0);

      // R8: out-of-range address
      bus_write(2'b10, 8'd9, 8'h77);
      check("R8 out-of-range write ignored", reg_bank, snap);
      check("R8 no pulse out of range", pulses, p0);
      bus_read(2'b10, 8'd9, rd, drv, drv_after);
      check("R8 out-of-range reads zero", {24'b0, rd}, 32'h0);
      check("R8 drive for out-of-range read", {31'b0, drv}, 32'h1);

      // R7: read and write together
      @(negedge clk); addr_in = 8'd2; host_d = 8'h00; host_en = 1'b1; sel_n = 2'b10;
      @(negedge clk); wr_n = 1'b0; rd_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 no drive on clash", {31'b0, bus_drive}, 32'h0);
      wr_n = 1'b1; rd_n = 1'b1;
      @(negedge clk); sel_n = 2'b11; host_en = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 clash writes nothing", reg_bank, snap);
      check("R7 no pulse on clash", pulses, p0);

      // R9: idle, selected but no strobe
      sel_n = 2'b10;
      repeat (6) @(negedge clk);
      check("R9 idle keeps bank", reg_bank, snap);
      check("R9 idle releases bus", {31'b0, bus_drive}, 32'h0);
      sel_n = 2'b11;

      // R1: reset in mid-use, asynchronous
      @(negedge clk); bus_rst = 1'b1; #0.5;
      check("R1 async clear", reg_bank, 32'h0);
      @(negedge clk); bus_rst = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 bank stays clear", reg_bank, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #60000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule